// File: doc/BRIEF.md
# Pixel Depth Palette Mapper

This block turns a stream of packed 16-bit display-memory words into a stream of RGB pixels for a panel or CRT pipeline. A word is split into 16, 8, 4, 2 or 1 pixels, depending on the depth selected for it. At depths of 8 bits or fewer, each pixel selects one entry in each of three 4-bit colour tables: one for red, one for green and one for blue. At the two high-colour depths the tables are skipped and the colour fields of the pixel are used directly. When the target is a passive panel, each direct field is cut down to its 4 most significant bits.

A CPU writes all three tables in a single cycle through a dedicated write port. Memory words come in on a valid/ready stream and pixels leave on a valid/ready stream. The colour result passes through one output register. Every output channel is widened to the output width by repeating its bits, so a field that is all ones gives full intensity.

Top module: `pxmap_top`

## Requirements
- R1: `mode_sel` codes 0, 1, 2, 3, 4 and 5 select 1, 2, 4, 8, 15 and 16 bits per pixel; codes 6 and 7 behave as 16 bits per pixel; one word yields 16, 8, 4, 2, 1 and 1 pixels respectively.
- R2: Pixels are taken from a word starting at bit 15, so the most significant pixel leaves first.
- R3: At 1, 2, 4 and 8 bits per pixel, the pixel value, zero-extended to 8 bits, is the index into all three tables. Depths below 8 reach only entries 0 to 2^depth-1.
- R4: A 4-bit table value is widened to `OUT_W` bits by repeating it from the MSB down (with `OUT_W`=8, 0xF gives 0xFF and 0xA gives 0xAA).
- R5: At 16 bits per pixel with `panel_passive`=0, red is bits 15:11, green is bits 10:5 and blue is bits 4:0. Each field is widened to `OUT_W` by repeating its bits.
- R6: At 15 bits per pixel, red is bits 14:10, green is bits 9:5 and blue is bits 4:0, each widened by repetition. Bit 15 has no effect.
- R7: With `panel_passive`=1, the direct path keeps only the top 4 bits of each field and then widens them by repetition. Table-mapped depths are not affected by this input.
- R8: When `lut_we` is high, the three table entries at `lut_idx` take `lut_wr_r`, `lut_wr_g` and `lut_wr_b` at the clock edge. A lookup at that same edge returns the values held before the write.
- R9: While `out_valid` is high and `out_ready` is low, the output holds steady. Each pixel is delivered exactly once and in order. `in_ready` is high only when the unpacker is empty or its last pixel is leaving.
- R10: During reset, and on the first cycle after it, `out_valid` is low and `in_ready` is high.
- R11: The depth is captured when a word is accepted. Changing `mode_sel` while that word is being unpacked does not affect its pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | Depth code, captured per accepted word |
| panel_passive | input | 1 | 1 = passive panel target (4-bit direct fields) |
| lut_we | input | 1 | Table write strobe |
| lut_idx | input | 8 | Table write index |
| lut_wr_r | input | 4 | Red table write value |
| lut_wr_g | input | 4 | Green table write value |
| lut_wr_b | input | 4 | Blue table write value |
| in_valid | input | 1 | Memory word valid |
| in_ready | output | 1 | Memory word accepted when high with in_valid |
| in_word | input | 16 | Packed memory word |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Pixel consumer ready |
| out_r | output | OUT_W | Red channel |
| out_g | output | OUT_W | Green channel |
| out_b | output | OUT_W | Blue channel |

## Verification
The bench builds the block with its default parameters: 16-bit words, 4-bit tables with 256 entries, and `OUT_W` of 8. At this output width, table values, 5-bit direct fields and the 6-bit green field each need a different amount of repetition to fill the channel. One bench model therefore exercises all three widening cases, and the passive-panel truncation as well. The bench throttles the output with a pseudo-random ready pattern, so stalls occur at every pixel position within a word. One directed sequence forces a table write onto the exact edge of a lookup.

// File: rtl/pxmap_pkg.sv
package pxmap_pkg;

   typedef enum logic [2:0] {
      DEP_1  = 3'd0,
      DEP_2  = 3'd1,
      DEP_4  = 3'd2,
      DEP_8  = 3'd3,
      DEP_15 = 3'd4,
      DEP_16 = 3'd5
   } depth_e;

   // codes 6 and 7 fold onto the widest depth
   function automatic depth_e decode_depth(input logic [2:0] code);
      case (code)
         3'd0:    return DEP_1;
         3'd1:    return DEP_2;
         3'd2:    return DEP_4;
         3'd3:    return DEP_8;
         3'd4:    return DEP_15;
         default: return DEP_16;
      endcase
   endfunction

   function automatic logic [4:0] bits_of(input depth_e d);
      case (d)
         DEP_1:   return 5'd1;
         DEP_2:   return 5'd2;
         DEP_4:   return 5'd4;
         DEP_8:   return 5'd8;
         default: return 5'd16;
      endcase
   endfunction

   function automatic logic [4:0] count_of(input depth_e d);
      case (d)
         DEP_1:   return 5'd16;
         DEP_2:   return 5'd8;
         DEP_4:   return 5'd4;
         DEP_8:   return 5'd2;
         default: return 5'd1;
      endcase
   endfunction

   function automatic logic is_table_depth(input depth_e d);
      return (d == DEP_1) || (d == DEP_2) || (d == DEP_4) || (d == DEP_8);
   endfunction

   // widen a w-bit value to ow bits by repeating it from the MSB down
   function automatic logic [15:0] rep_msb(input logic [7:0] v, input int unsigned w,
                                           input int unsigned ow);
      logic [15:0] r;
      r = '0;
      for (int unsigned i = 0; i < 16; i++) begin
         if (i < ow) r[i] = v[3'(w - 1 - ((ow - 1 - i) % w))];
      end
      return r;
   endfunction

endpackage

// File: rtl/pxmap_unpack.sv
module pxmap_unpack
   import pxmap_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_sel,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_word,
   output logic              pix_valid,
   input  logic              pix_ready,
   output logic [WORD_W-1:0] pix_val,
   output depth_e            pix_depth
);

   localparam int CNT_W = $clog2(WORD_W) + 1;

   logic [WORD_W-1:0] word_q;
   logic [CNT_W-1:0]  left_q;
   depth_e            depth_q;
   logic              take_word, take_pix;

   assign pix_valid = (left_q != '0);
   assign take_pix  = pix_valid && pix_ready;
   assign in_ready  = !pix_valid || (pix_ready && left_q == CNT_W'(1));
   assign take_word = in_valid && in_ready;
   assign pix_depth = depth_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q  <= '0;
         left_q  <= '0;
         depth_q <= DEP_1;
      end else if (take_word) begin
         word_q  <= in_word;
         depth_q <= decode_depth(mode_sel);
         left_q  <= CNT_W'(count_of(decode_depth(mode_sel)));
      end else if (take_pix) begin
         word_q  <= word_q << bits_of(depth_q);
         left_q  <= left_q - CNT_W'(1);
      end
   end

   always_comb begin
      pix_val = '0;
      case (depth_q)
         DEP_1:   pix_val[0]   = word_q[WORD_W-1];
         DEP_2:   pix_val[1:0] = word_q[WORD_W-1 -: 2];
         DEP_4:   pix_val[3:0] = word_q[WORD_W-1 -: 4];
         DEP_8:   pix_val[7:0] = word_q[WORD_W-1 -: 8];
         default: pix_val      = word_q;
      endcase
   end

endmodule

// File: rtl/pxmap_lut.sv
module pxmap_lut #(
   parameter int IDX_W    = 8,
   parameter int LUT_BITS = 4
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [2:0][LUT_BITS-1:0] wr_data,
   input  logic [IDX_W-1:0]         rd_idx,
   output logic [2:0][LUT_BITS-1:0] rd_data
);

   localparam int DEPTH = 1 << IDX_W;

   // channel 2 = red, 1 = green, 0 = blue
   for (genvar ch = 0; ch < 3; ch++) begin : g_chan
      logic [LUT_BITS-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en) mem[wr_idx] <= wr_data[ch];
      end

      assign rd_data[ch] = mem[rd_idx];
   end

endmodule

// File: rtl/pxmap_direct.sv
module pxmap_direct
   import pxmap_pkg::*;
#(
   parameter int OUT_W = 8
) (
   input  logic [15:0]            pix,
   input  logic                   is15,
   input  logic                   passive,
   output logic [2:0][OUT_W-1:0]  rgb
);

   logic [4:0]  r5, b5, g5;
   logic [5:0]  g6;
   logic [15:0] full_r, full_g, full_b, trn_r, trn_g, trn_b;

   assign r5 = is15 ? pix[14:10] : pix[15:11];
   assign g5 = pix[9:5];
   assign g6 = pix[10:5];
   assign b5 = pix[4:0];

   assign full_r = rep_msb({3'b0, r5}, 5, OUT_W);
   assign full_g = is15 ? rep_msb({3'b0, g5}, 5, OUT_W) : rep_msb({2'b0, g6}, 6, OUT_W);
   assign full_b = rep_msb({3'b0, b5}, 5, OUT_W);

   assign trn_r = rep_msb({4'b0, r5[4:1]}, 4, OUT_W);
   assign trn_g = is15 ? rep_msb({4'b0, g5[4:1]}, 4, OUT_W) : rep_msb({4'b0, g6[5:2]}, 4, OUT_W);
   assign trn_b = rep_msb({4'b0, b5[4:1]}, 4, OUT_W);

   assign rgb[2] = passive ? trn_r[OUT_W-1:0] : full_r[OUT_W-1:0];
   assign rgb[1] = passive ? trn_g[OUT_W-1:0] : full_g[OUT_W-1:0];
   assign rgb[0] = passive ? trn_b[OUT_W-1:0] : full_b[OUT_W-1:0];

endmodule

// File: rtl/pxmap_top.sv
module pxmap_top
   import pxmap_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int IDX_W    = 8,
   parameter int LUT_BITS = 4,
   parameter int OUT_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          mode_sel,
   input  logic                panel_passive,
   input  logic                lut_we,
   input  logic [IDX_W-1:0]    lut_idx,
   input  logic [LUT_BITS-1:0] lut_wr_r,
   input  logic [LUT_BITS-1:0] lut_wr_g,
   input  logic [LUT_BITS-1:0] lut_wr_b,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [WORD_W-1:0]   in_word,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [OUT_W-1:0]    out_r,
   output logic [OUT_W-1:0]    out_g,
   output logic [OUT_W-1:0]    out_b
);

   if (WORD_W != 16) begin : g_bad_word
      $error("pxmap_top: WORD_W must be 16 for the 5-6-5 and 5-5-5 layouts");
   end
   if (IDX_W != 8) begin : g_bad_idx
      $error("pxmap_top: IDX_W must be 8 to cover the 8 bpp index range");
   end
   if (LUT_BITS < 1 || LUT_BITS > 8) begin : g_bad_lut
      $error("pxmap_top: LUT_BITS must be 1..8");
   end
   if (OUT_W < 4 || OUT_W > 16) begin : g_bad_out
      $error("pxmap_top: OUT_W must be 4..16");
   end

   logic                     pix_valid, pix_ready, advance;
   logic [WORD_W-1:0]        pix_val;
   depth_e                   pix_depth;
   logic [2:0][LUT_BITS-1:0] lut_rd;
   logic [2:0][OUT_W-1:0]    tbl_rgb, dir_rgb, mix_rgb;

   pxmap_unpack #(.WORD_W(WORD_W)) u_unpack (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_sel  (mode_sel),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_word   (in_word),
      .pix_valid (pix_valid),
      .pix_ready (pix_ready),
      .pix_val   (pix_val),
      .pix_depth (pix_depth)
   );

   pxmap_lut #(.IDX_W(IDX_W), .LUT_BITS(LUT_BITS)) u_lut (
      .clk     (clk),
      .wr_en   (lut_we),
      .wr_idx  (lut_idx),
      .wr_data ({lut_wr_r, lut_wr_g, lut_wr_b}),
      .rd_idx  (pix_val[IDX_W-1:0]),
      .rd_data (lut_rd)
   );

   for (genvar ch = 0; ch < 3; ch++) begin : g_widen
      logic [15:0] wide;
      assign wide        = rep_msb(8'(lut_rd[ch]), LUT_BITS, OUT_W);
      assign tbl_rgb[ch] = wide[OUT_W-1:0];
   end

   pxmap_direct #(.OUT_W(OUT_W)) u_direct (
      .pix     (pix_val),
      .is15    (pix_depth == DEP_15),
      .passive (panel_passive),
      .rgb     (dir_rgb)
   );

   assign mix_rgb   = is_table_depth(pix_depth) ? tbl_rgb : dir_rgb;
   assign pix_ready = !out_valid || out_ready;
   assign advance   = pix_valid && pix_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_r     <= '0;
         out_g     <= '0;
         out_b     <= '0;
      end else if (advance) begin
         out_valid <= 1'b1;
         out_r     <= mix_rgb[2];
         out_g     <= mix_rgb[1];
         out_b     <= mix_rgb[0];
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/pxmap_chk.sv
module pxmap_chk #(
   parameter int OUT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       mode_sel,
   input logic             in_valid,
   input logic             in_ready,
   input logic             pix_valid,
   input logic             pix_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [OUT_W-1:0] out_r,
   input logic [OUT_W-1:0] out_g,
   input logic [OUT_W-1:0] out_b
);

   // R10
   reset_idle_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (!out_valid && in_ready));

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b)));

   // R9
   pix_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_ready) |=> out_valid);

   // R1
   wide_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && mode_sel[2]) |=> (pix_valid && (in_ready == pix_ready)));

   // R1
   mono_many_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && mode_sel == 3'd0) |=> (pix_valid && !in_ready));

endmodule

bind pxmap_top pxmap_chk #(.OUT_W(OUT_W)) u_chk (.*);

// File: tb/sim_pxmap_top.sv
module sim_pxmap_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode_sel = '0;
   logic        panel_passive = 1'b0;
   logic        lut_we = 1'b0;
   logic [7:0]  lut_idx = '0;
   logic [3:0]  lut_wr_r = '0, lut_wr_g = '0, lut_wr_b = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_word = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [7:0]  out_r, out_g, out_b;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   pxmap_top u0 (.*);

   // bench-side tables and scoreboard
   logic [3:0]  sh_r [256];
   logic [3:0]  sh_g [256];
   logic [3:0]  sh_b [256];
   logic [23:0] exp_q [0:2047];
   string       tag_q [0:2047];
   int          wr_p = 0, rd_p = 0;
   logic        force_rdy = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   function automatic logic [7:0] e4(input logic [3:0] v); return {v, v}; endfunction
   function automatic logic [7:0] e5(input logic [4:0] v); return {v, v[4:2]}; endfunction
   function automatic logic [7:0] e6(input logic [5:0] v); return {v, v[5:4]}; endfunction

   function automatic int bpp(input logic [2:0] m);
      case (m)
         3'd0: return 1;  3'd1: return 2;  3'd2: return 4;  3'd3: return 8;
         default: return 16;
      endcase
   endfunction

   function automatic logic [23:0] model(input logic [2:0] m, input logic pas, input logic [15:0] p);
      logic [7:0] idx;
      if (m <= 3'd3) begin
         idx = p[7:0];
         return {e4(sh_r[idx]), e4(sh_g[idx]), e4(sh_b[idx])};
      end else if (m == 3'd4) begin
         if (pas) return {e4(p[14:11]), e4(p[9:6]), e4(p[4:1])};
         return {e5(p[14:10]), e5(p[9:5]), e5(p[4:0])};
      end else begin
         if (pas) return {e4(p[15:12]), e4(p[10:7]), e4(p[4:1])};
         return {e5(p[15:11]), e6(p[10:5]), e5(p[4:0])};
      end
   endfunction

   task automatic push_word(input logic [2:0] m, input logic [15:0] w, input string tag);
      int b = bpp(m);
      for (int k = 0; k < 16 / b; k++) begin
         logic [15:0] p = (w >> (16 - b * (k + 1))) & ((b == 16) ? 16'hFFFF : 16'((1 << b) - 1));
         exp_q[wr_p] = model(m, panel_passive, p);
         tag_q[wr_p] = tag;
         wr_p++;
      end
   endtask

   task automatic send(input logic [2:0] m, input logic [15:0] w, input string tag);
      @(negedge clk);
      mode_sel = m; in_valid = 1'b1; in_word = w;
      #3;
      while (!in_ready) begin
         @(negedge clk);
         #3;
      end
      push_word(m, w, tag);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic drain();
      while (rd_p != wr_p) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic lut_write(input logic [7:0] i, input logic [3:0] r, input logic [3:0] g,
                            input logic [3:0] b);
      @(negedge clk);
      lut_we = 1'b1; lut_idx = i; lut_wr_r = r; lut_wr_g = g; lut_wr_b = b;
      sh_r[i] = r; sh_g[i] = g; sh_b[i] = b;
      @(negedge clk);
      lut_we = 1'b0;
   endtask

   task automatic check1(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // output monitor: ready pattern set at the falling edge, sampled shortly after
   always begin
      @(negedge clk);
      out_ready = force_rdy ? 1'b1 : (lfsr[0] | lfsr[3]);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      #2;
      if (rst_n && out_valid && out_ready) begin
         if (rd_p >= wr_p) begin
            check1(1'b0, "R9 unexpected pixel", {8'h0, out_r, out_g, out_b}, 32'h0);
         end else begin
            check1({out_r, out_g, out_b} == exp_q[rd_p], tag_q[rd_p],
                   {8'h0, out_r, out_g, out_b}, {8'h0, exp_q[rd_p]});
            rd_p++;
         end
      end
   end

   // {mode, passive, word}
   localparam logic [19:0] VEC [14] = '{
      {3'd0, 1'b0, 16'hA5C3}, {3'd1, 1'b0, 16'h1B4E}, {3'd2, 1'b0, 16'hF0A7},
      {3'd3, 1'b0, 16'h3CFF}, {3'd5, 1'b0, 16'hF81F}, {3'd5, 1'b0, 16'h07E0},
      {3'd4, 1'b0, 16'h7C1F}, {3'd4, 1'b0, 16'hFC1F}, {3'd6, 1'b0, 16'h1234},
      {3'd7, 1'b0, 16'hABCD}, {3'd5, 1'b1, 16'hB6D5}, {3'd4, 1'b1, 16'h56AB},
      {3'd4, 1'b1, 16'hD6AB}, {3'd3, 1'b1, 16'h8001}
   };

   function automatic string vec_tag(input logic [2:0] m, input logic pas);
      if (m >= 3'd6) return "R1";
      if (pas && m >= 3'd4) return "R7";
      if (m == 3'd5) return "R5";
      if (m == 3'd4) return "R6";
      if (m == 3'd3) return "R3";
      return "R2";
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", rd_p, wr_p);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: idle during reset
      #2;
      check1(!out_valid, "R10 out_valid in reset", 32'(out_valid), 0);
      check1(in_ready, "R10 in_ready in reset", 32'(in_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      #3;
      check1(!out_valid, "R10 out_valid after reset", 32'(out_valid), 0);
      check1(in_ready, "R10 in_ready after reset", 32'(in_ready), 1);

      for (int i = 0; i < 256; i++) begin
         lut_write(8'(i), 4'(i) ^ 4'(i >> 4), ~4'(i), 4'(i >> 4) + 4'(i));
      end

      // vector table walk
      for (int v = 0; v < 14; v++) begin
         if (VEC[v][16] != panel_passive) begin
            drain();
            panel_passive = VEC[v][16];
         end
         send(VEC[v][19:17], VEC[v][15:0], vec_tag(VEC[v][19:17], VEC[v][16]));
      end
      drain();
      panel_passive = 1'b0;

      // R4: replication of extreme table values
      lut_write(8'h00, 4'hF, 4'h0, 4'hA);
      send(3'd3, 16'h0000, "R4");
      drain();

      // R3: 1 bpp index reaches entries 0 and 1 only
      lut_write(8'h01, 4'h3, 4'hC, 4'h5);
      send(3'd0, 16'h8001, "R3");
      drain();

      // R11: mode changes while a 1 bpp word is still unpacking
      send(3'd0, 16'hC3A5, "R11");
      mode_sel = 3'd5;
      repeat (20) @(negedge clk);
      send(3'd2, 16'h1F2E, "R11");
      mode_sel = 3'd0;
      drain();

      // R8: table write on the same edge as a lookup returns old values
      lut_write(8'h21, 4'h1, 4'h2, 4'h3);
      lut_write(8'h22, 4'h4, 4'h5, 4'h6);
      force_rdy = 1'b1;
      repeat (3) @(negedge clk);
      mode_sel = 3'd3; in_valid = 1'b1; in_word = 16'h2122;
      #3;
      check1(in_ready, "R8 setup in_ready", 32'(in_ready), 1);
      push_word(3'd3, 16'h2122, "R8 old value");
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      lut_we = 1'b1; lut_idx = 8'h22; lut_wr_r = 4'h9; lut_wr_g = 4'hA; lut_wr_b = 4'hB;
      sh_r[8'h22] = 4'h9; sh_g[8'h22] = 4'hA; sh_b[8'h22] = 4'hB;
      @(negedge clk);
      lut_we = 1'b0;
      drain();
      send(3'd3, 16'h2222, "R8 new value");
      drain();
      force_rdy = 1'b0;

      // R9: long back-to-back run under random backpressure
      for (int n = 0; n < 40; n++) begin
         send(3'(n % 6), 16'(n * 16'h3D1B + 16'h0F0F), "R9");
      end
      drain();
      check1(rd_p == wr_p, "R9 pixel count", 32'(rd_p), 32'(wr_p));
      check1(!out_valid, "R9 idle after drain", 32'(out_valid), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule